// File: doc/BRIEF.md
# Shifted-Template Noise Combiner with Carrier Mixer

This block turns one stored, band-limited noise template into a noise stream that does not repeat. A host loads a complex time-domain template into on-chip storage while the block is stopped. The template's bandwidth is fixed by the spectral window used when it was made. Once running, several readers walk the template in parallel. Each reader jumps to a pseudo-random start offset every time it runs off the end. Their samples are summed, scaled down, saturated and then mixed onto a carrier set by a frequency word. The real part of that complex product leaves the block as a 16-bit stream.

The output is a valid/ready stream. A sample is transferred on a clock edge where `o_valid` and `o_ready` are both high. While `o_valid` is high and `o_ready` is low, the sample and all internal state stay frozen. The block makes a new sample on an edge where `en` is high and the output register is empty or being drained. Lowering `en` stops new samples, but a sample already offered stays offered until it is taken. Template loading and the frequency word are plain control inputs.

Top module: `nsup_noise_top`

## Requirements
- R1: After reset `o_valid` is 0 and `o_data` is 0. No sample appears until `en` has been high at a clock edge.
- R2: A write (`wr_en` high) with `en` low stores `wr_data` at `wr_addr`, with the real part in bits 31:16 and the imaginary part in bits 15:0. A write with `en` high is ignored and leaves the stored template unchanged.
- R3: Reader k (k = 0..READERS-1) starts at address k*DEPTH/READERS. Its 32-bit LFSR starts at SEED_BASE + k*0x9E3779B9. On every produced sample each reader reads its current address and then steps. If the address was DEPTH-1, the LFSR steps as s' = (s>>1) XOR (s[0] ? 0x80200003 : 0) and the new address is s'[9:0]. Otherwise the address increments by 1.
- R4: The real parts of the READERS template samples are added, arithmetically shifted right by log2(READERS) and saturated to 16-bit signed. The imaginary parts are treated the same way.
- R5: Sine lookup index i (8 bits) uses a 64-entry quarter table q[j] = floor(32767*16*p / (327680 - 4*p)), with n = 2j+1 and p = n*(256-n). The lookup returns q[j] with j = i[6] ? 63-i[5:0] : i[5:0], negated when i[7] is 1. The cosine at index i is the sine at index (i+64) mod 256.
- R6: For combined sample (I, Q) and phase index i = phase[23:16], the output is sat16(floor((I*cos(i) - Q*sin(i)) / 2^15)).
- R7: While `o_valid` is 1 and `o_ready` is 0, `o_valid` stays 1 and `o_data` is unchanged on the next cycle.
- R8: With `en` low no new sample is produced. A sample that was accepted is followed by `o_valid` 0.
- R9: The 24-bit phase starts at 0. After each produced sample the phase adds the current `freq_word`, modulo 2^24. The sample uses the phase value from before that addition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; template writes are accepted only while low |
| freq_word | input | 24 | Carrier phase increment per produced sample |
| wr_en | input | 1 | Template write strobe |
| wr_addr | input | 10 | Template write address |
| wr_data | input | 32 | Template sample, real part in bits 31:16 and imaginary part in bits 15:0 |
| o_valid | output | 1 | Output sample valid |
| o_ready | input | 1 | Downstream ready |
| o_data | output | 16 | Mixed noise sample, signed |

## Verification
The assertions assume that the sink follows valid/ready rules and that `rst_n` is held low for at least one edge before anything else. They put no limit on `freq_word` or on how `en` and `o_ready` toggle. The stimulus drives `en`, `o_ready` and the frequency word from `$urandom` with a fixed seed, changing them only at falling edges. Writes made while enabled are aimed at the address reader 0 is about to read, so an ignored write would show up at the output. A full-scale template drives the mixer into both saturation limits.

// File: rtl/nsup_pkg.sv
package nsup_pkg;

  typedef struct packed {
    logic signed [15:0] re;
    logic signed [15:0] im;
  } cplx_t;

  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

  // Galois right-shift step of the offset generator
  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? LFSR_TAPS : 32'h0);
  endfunction

  // Rational sine approximation sampled at odd 1/512 points of a period
  function automatic logic signed [15:0] quarter_sine(input int j);
    longint n, p, v;
    n = 2 * j + 1;
    p = n * (256 - n);
    v = (longint'(32767) * 16 * p) / (longint'(327680) - 4 * p);
    return 16'(v);
  endfunction

endpackage

// File: rtl/nsup_template_mem.sv
module nsup_template_mem
  import nsup_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int READERS = 4,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  cplx_t         wr_data,
  input  logic [AW-1:0] rd_addr [READERS],
  output cplx_t         rd_data [READERS]
);

  cplx_t store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  for (genvar g = 0; g < READERS; g++) begin : g_port
    assign rd_data[g] = store[rd_addr[g]];
  end

endmodule

// File: rtl/nsup_reader.sv
module nsup_reader
  import nsup_pkg::*;
#(
  parameter int          DEPTH = 1024,
  parameter logic [31:0] SEED  = 32'h1D2C_3B4A,
  parameter int          START = 0,
  localparam int         AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [31:0] lfsr_q;
  logic [31:0] lfsr_nx;

  assign lfsr_nx = lfsr_step(lfsr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= AW'(START);
      lfsr_q <= SEED;
    end else if (adv) begin
      if (addr == LAST) begin
        lfsr_q <= lfsr_nx;
        addr   <= lfsr_nx[AW-1:0];
      end else begin
        addr <= addr + 1'b1;
      end
    end
  end

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv && addr != LAST |=> addr == $past(addr) + 1'b1);
  a_r3_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(addr) && $stable(lfsr_q));
  a_r3_redraw: assert property (@(posedge clk) disable iff (!rst_n)
    adv && addr == LAST |=> lfsr_q != $past(lfsr_q));

endmodule

// File: rtl/nsup_mixer.sv
module nsup_mixer
  import nsup_pkg::*;
#(
  parameter int PHASE_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic [PHASE_W-1:0] freq,
  input  cplx_t              smp,
  output logic signed [15:0] mix
);

  logic [PHASE_W-1:0] phase_q;
  logic signed [15:0] qtab [64];

  for (genvar g = 0; g < 64; g++) begin : g_tab
    assign qtab[g] = quarter_sine(g);
  end

  logic [7:0]         idx_s, idx_c;
  logic [5:0]         js, jc;
  logic signed [15:0] sn, cs;
  logic signed [31:0] pc, ps;
  logic signed [32:0] acc;
  logic signed [17:0] sh;

  always_comb begin
    idx_s = phase_q[PHASE_W-1 -: 8];
    idx_c = idx_s + 8'd64;
    js = idx_s[6] ? ~idx_s[5:0] : idx_s[5:0];
    jc = idx_c[6] ? ~idx_c[5:0] : idx_c[5:0];
    sn = idx_s[7] ? -qtab[js] : qtab[js];
    cs = idx_c[7] ? -qtab[jc] : qtab[jc];
    pc = 32'(smp.re) * 32'(cs);
    ps = 32'(smp.im) * 32'(sn);
    acc = {pc[31], pc} - {ps[31], ps};
    sh = 18'(acc >>> 15);
    if (sh > 18'sd32767)       mix = 16'sh7FFF;
    else if (sh < -18'sd32768) mix = -16'sh8000;
    else                       mix = sh[15:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   phase_q <= '0;
    else if (adv) phase_q <= phase_q + freq;
  end

  a_r9_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> phase_q == $past(phase_q) + $past(freq));
  a_r9_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(phase_q));

endmodule

// File: rtl/nsup_noise_top.sv
module nsup_noise_top
  import nsup_pkg::*;
#(
  parameter int          DEPTH     = 1024,
  parameter int          READERS   = 4,
  parameter int          PHASE_W   = 24,
  parameter logic [31:0] SEED_BASE = 32'h1D2C_3B4A
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [PHASE_W-1:0]       freq_word,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [31:0]              wr_data,
  output logic                     o_valid,
  input  logic                     o_ready,
  output logic [15:0]              o_data
);

  localparam int AW  = $clog2(DEPTH);
  localparam int RB  = $clog2(READERS);
  localparam int SPC = DEPTH / READERS;

  logic adv;
  assign adv = en && (!o_valid || o_ready);

  logic [AW-1:0] rd_addr [READERS];
  cplx_t         rd_data [READERS];

  nsup_template_mem #(.DEPTH(DEPTH), .READERS(READERS)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en && !en),
    .wr_addr (wr_addr),
    .wr_data (cplx_t'(wr_data)),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  for (genvar g = 0; g < READERS; g++) begin : g_rd
    nsup_reader #(
      .DEPTH (DEPTH),
      .SEED  (SEED_BASE + 32'(g) * 32'h9E37_79B9),
      .START (g * SPC)
    ) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .addr  (rd_addr[g])
    );
  end

  logic signed [15+RB:0] sum_re, sum_im, scl_re, scl_im;
  cplx_t                 comb_s;

  function automatic logic signed [15:0] clip(input logic signed [15+RB:0] v);
    if (v > (16+RB)'(32767))       return 16'sh7FFF;
    else if (v < -(16+RB)'(32768)) return -16'sh8000;
    else                           return v[15:0];
  endfunction

  always_comb begin
    sum_re = '0;
    sum_im = '0;
    for (int k = 0; k < READERS; k++) begin
      sum_re = sum_re + {{RB{rd_data[k].re[15]}}, rd_data[k].re};
      sum_im = sum_im + {{RB{rd_data[k].im[15]}}, rd_data[k].im};
    end
    scl_re = sum_re >>> RB;
    scl_im = sum_im >>> RB;
    comb_s.re = clip(scl_re);
    comb_s.im = clip(scl_im);
  end

  logic signed [15:0] mix;

  nsup_mixer #(.PHASE_W(PHASE_W)) u_mix (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .freq  (freq_word),
    .smp   (comb_s),
    .mix   (mix)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= '0;
    end else if (adv) begin
      o_valid <= 1'b1;
      o_data  <= mix;
    end else if (o_ready) begin
      o_valid <= 1'b0;
    end
  end

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |=> o_valid && $stable(o_data));
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en && (o_ready || !o_valid) |=> !o_valid);
  a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
    !o_valid && !en |=> !o_valid && $stable(o_data));

endmodule

// File: tb/nsup_noise_top_tb_top.sv
module nsup_noise_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [23:0] freq_word = '0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        o_valid;
  logic        o_ready = 1'b0;
  logic [15:0] o_data;

  always #5 clk = ~clk;

  nsup_noise_top dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .freq_word(freq_word),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] m_tmpl [1024];
  logic [9:0]  m_addr [4];
  logic [31:0] m_lfsr [4];
  logic [23:0] m_phase;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint qs(input int j);
    longint n, p;
    n = 2 * j + 1;
    p = n * (256 - n);
    return (longint'(32767) * 16 * p) / (longint'(327680) - 4 * p);
  endfunction

  function automatic longint wave(input logic [7:0] i);
    int j;
    j = i[6] ? 63 - int'(i[5:0]) : int'(i[5:0]);
    return i[7] ? -qs(j) : qs(j);
  endfunction

  function automatic longint sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic logic [31:0] lstep(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  function automatic logic [15:0] model_sample();
    longint sr = 0, si = 0, acc;
    logic [7:0] ix;
    for (int k = 0; k < 4; k++) begin
      sr += longint'($signed(m_tmpl[m_addr[k]][31:16]));
      si += longint'($signed(m_tmpl[m_addr[k]][15:0]));
    end
    sr = sat(sr >>> 2);
    si = sat(si >>> 2);
    ix = m_phase[23:16];
    acc = sr * wave(ix + 8'd64) - si * wave(ix);
    return 16'(sat(acc >>> 15));
  endfunction

  task automatic model_advance();
    m_phase = m_phase + freq_word;
    for (int k = 0; k < 4; k++) begin
      if (m_addr[k] == 10'd1023) begin
        m_lfsr[k] = lstep(m_lfsr[k]);
        m_addr[k] = m_lfsr[k][9:0];
      end else begin
        m_addr[k] = m_addr[k] + 10'd1;
      end
    end
  endtask

  task automatic model_reset();
    m_phase = '0;
    for (int k = 0; k < 4; k++) begin
      m_addr[k] = 10'(k * 256);
      m_lfsr[k] = 32'h1D2C_3B4A + 32'(k) * 32'h9E37_79B9;
    end
  endtask

  // one cycle: inputs set at a falling edge, results checked at the next one
  task automatic step(input bit e, input bit r, input string tag);
    bit adv, pv;
    logic [15:0] pd, ex;
    en = e;
    o_ready = r;
    pv = o_valid;
    pd = o_data;
    adv = e && (!o_valid || r);
    ex = '0;
    if (adv) begin
      ex = model_sample();
      model_advance();
    end
    @(negedge clk);
    if (adv)
      check(o_valid && o_data == ex, tag, longint'($signed(o_data)), longint'($signed(ex)));
    else if (pv && !r)
      check(o_valid && o_data == pd, "R7 hold", longint'($signed(o_data)), longint'($signed(pd)));
    else
      check(!o_valid, "R8 no new sample", longint'(o_valid), 0);
  endtask

  task automatic write(input logic [9:0] a, input logic [31:0] d, input bit model_it);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (model_it) m_tmpl[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(!o_valid && o_data == 16'd0, "R1 reset state", longint'(o_data), 0);

    // R2: load a random template while stopped
    for (int a = 0; a < 1024; a++) write(10'(a), $urandom(), 1'b1);
    check(!o_valid, "R1 no output before enable", longint'(o_valid), 0);

    // R3 R4 R5 R6 R9: free-running, random carrier
    freq_word = 24'($urandom());
    for (int i = 0; i < 1500; i++) step(1'b1, 1'b1, "R3 R4 R5 R6 R9 sample");

    // R7 R8: random enable and back-pressure, carrier retuned now and then
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) freq_word = 24'($urandom());
      step(($urandom() % 4) != 0, ($urandom() % 3) != 0, "R7 R8 R9 sample");
    end

    // R2: write while enabled aimed at reader 0's next addresses, must be ignored
    en = 1'b1; o_ready = 1'b0;
    for (int w = 1; w <= 4; w++) begin
      wr_en = 1'b1; wr_addr = m_addr[0] + 10'(w); wr_data = ~m_tmpl[m_addr[0] + 10'(w)];
      step(1'b1, 1'b0, "R2 R7 hold during write");
    end
    wr_en = 1'b0;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, "R2 write ignored while enabled");
    step(1'b0, 1'b1, "R8 drain");

    // R4 R6: full-scale template to reach the saturation limits
    for (int a = 0; a < 1024; a++) write(10'(a), {16'sh7FFF, 16'sh8000}, 1'b1);
    freq_word = 24'h0A0000;
    for (int i = 0; i < 200; i++) step(1'b1, 1'b1, "R4 R6 saturation");
    freq_word = 24'hFFFFFF;
    for (int i = 0; i < 50; i++) step(1'b1, ($urandom() % 2) == 1, "R9 phase wrap");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule